// File: doc/BRIEF.md
# Radio Module Power Sequencer

This block sits on the host side of a radio module and owns the four control lines that bring the module up and take it down: the battery-rail enable, the I/O-rail enable, the chip enable and the active-low module reset. A single-cycle power-up request walks the lines high one at a time, and a single-cycle power-down request walks them low in the reverse order. Every line is a registered output that is always driven to 0 or 1, and all of them sit low after reset.

Consecutive steps are spaced by a parameterised number of clock cycles. The wait between chip enable and reset release is a separate, longer count so that the module's crystal oscillator can settle (5 ms at the default clock). A `ready` flag follows the reset release, and an `off` flag reports that every line is low. A power-down request that arrives while power-up is still in progress unwinds from whatever lines are already high.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `bat_en`, `io_en`, `chip_en`, `mod_rst_n` and `ready` are 0 and `off` is 1 after that edge.
- R2: A `up_req` pulse in the all-off state raises `bat_en` two cycles later, then `io_en` STEP_CYCLES later, then `chip_en` STEP_CYCLES after that, with one line changing per step.
- R3: `mod_rst_n` rises exactly SETTLE_CYCLES cycles after `chip_en` rises.
- R4: `ready` rises one cycle after `mod_rst_n` rises, and is never 1 while `mod_rst_n` is 0.
- R5: A `down_req` pulse while running drops `mod_rst_n` and `ready` two cycles later, then `chip_en`, `io_en` and `bat_en` each STEP_CYCLES after the previous one; `off` rises in the same cycle `bat_en` falls.
- R6: A `down_req` pulse during power-up stops the rise and lowers the lines already high in the power-down order, each STEP_CYCLES apart, ending in the all-off state.
- R7: When `up_req` and `down_req` are high in the same cycle in the all-off state, nothing rises; a lone `down_req` in the all-off state has no effect.
- R8: `up_req` is ignored while running and while a power-down is in progress.
- R9: At every cycle `io_en` implies `bat_en`, `chip_en` implies `io_en`, and `mod_rst_n` implies `chip_en`; no two of these four lines change in the same cycle outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the delay timebase |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse, wins over `up_req` |
| bat_en | output | 1 | Battery rail enable |
| io_en | output | 1 | I/O rail enable |
| chip_en | output | 1 | Module enable, low places it in power-down |
| mod_rst_n | output | 1 | Module reset, active low |
| ready | output | 1 | Module out of reset and usable |
| off | output | 1 | All four control lines low |

## Verification
The hardest situations to reach are the aborts: a power-down request has to land inside a specific power-up step, and the expected unwind depends on which lines are already high at that instant. The stimulus table counts cycles from the up request and fires the down request once during the battery-only step and once during the oscillator-settle wait, with a stray up request placed inside the resulting unwind. The settle count is shortened through the parameter so the full wait can be stepped through cycle by cycle.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power sequencer: the sequencing states and the
// vector of four control lines each state drives.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BAT   = 3'd1,
        ST_IO    = 3'd2,
        ST_CHIP  = 3'd3,
        ST_RUN   = 3'd4,
        ST_DRST  = 3'd5,
        ST_DCHIP = 3'd6,
        ST_DIO   = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic bat;
        logic io;
        logic chip;
        logic rel;
    } rail_vec_t;

    // Line levels held in each state; adjacent states differ in one line.
    function automatic rail_vec_t rails_of(seq_state_e s);
        rail_vec_t r;
        case (s)
            ST_OFF:   r = 4'b0000;
            ST_BAT:   r = 4'b1000;
            ST_IO:    r = 4'b1100;
            ST_CHIP:  r = 4'b1110;
            ST_RUN:   r = 4'b1111;
            ST_DRST:  r = 4'b1110;
            ST_DCHIP: r = 4'b1100;
            ST_DIO:   r = 4'b1000;
            default:  r = 4'b0000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
// Down-counter that times each sequencing step.
// Assumes: load pulses on every state change; sel_settle picks the long
// settle count instead of the step count. done is high once the loaded
// count has elapsed, so a state entered with load lasts exactly N cycles.
module pwr_seq_timer #(
    parameter int STEP_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_settle,
    output logic done
);
    localparam int MAXC = (SETTLE_CYCLES > STEP_CYCLES) ? SETTLE_CYCLES : STEP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STEP_LD   = CW'(STEP_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Reload on a state change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= sel_settle ? SETTLE_LD : STEP_LD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Sequencing state machine. Walks up through battery, I/O, chip enable and
// reset release, and down in reverse. A down request during power-up jumps
// to the power-down state whose line levels match the current ones.
// Assumes: requests are sampled every cycle; down wins over up.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_req,
    input  logic       down_req,
    input  logic       tmr_done,
    output seq_state_e state,
    output logic       load,
    output logic       sel_settle
);
    seq_state_e state_q, state_d;

    // Next-state choice from the current step, the requests and the timer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:   if (up_req && !down_req) state_d = ST_BAT;
            ST_BAT:   if (down_req) state_d = ST_DIO;
                      else if (tmr_done) state_d = ST_IO;
            ST_IO:    if (down_req) state_d = ST_DCHIP;
                      else if (tmr_done) state_d = ST_CHIP;
            ST_CHIP:  if (down_req) state_d = ST_DRST;
                      else if (tmr_done) state_d = ST_RUN;
            ST_RUN:   if (down_req) state_d = ST_DRST;
            ST_DRST:  if (tmr_done) state_d = ST_DCHIP;
            ST_DCHIP: if (tmr_done) state_d = ST_DIO;
            ST_DIO:   if (tmr_done) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign load       = (state_d != state_q);
    assign sel_settle = (state_d == ST_CHIP);
    assign state      = state_q;

endmodule

// File: rtl/pwr_seq_drive.sv
// Output stage: registers the four control lines from the current state so
// every pin comes straight from a flop, then derives ready and off.
// Assumes: state comes from a register; outputs lag the state by one cycle.
module pwr_seq_drive
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    output logic       bat_en,
    output logic       io_en,
    output logic       chip_en,
    output logic       mod_rst_n,
    output logic       ready,
    output logic       off
);
    rail_vec_t lines_q;
    logic      ready_q;
    logic      off_q;

    // Drive the control lines at the levels of the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= rails_of(state);
    end

    // Ready follows a released reset by one cycle; off tracks the idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            off_q   <= 1'b1;
        end else begin
            ready_q <= lines_q.rel && (state == ST_RUN);
            off_q   <= (state == ST_OFF);
        end
    end

    assign bat_en    = lines_q.bat;
    assign io_en     = lines_q.io;
    assign chip_en   = lines_q.chip;
    assign mod_rst_n = lines_q.rel;
    assign ready     = ready_q;
    assign off       = off_q;

endmodule

// File: rtl/pwr_seq_top.sv
// Radio module power sequencer top. Ties the step timer, the state machine
// and the registered output stage together.
// Assumes: STEP_CYCLES >= 1 and SETTLE_CYCLES >= 1, both in system-clock
// cycles; the default settle count is 5 ms at 250 MHz.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int STEP_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic down_req,
    output logic bat_en,
    output logic io_en,
    output logic chip_en,
    output logic mod_rst_n,
    output logic ready,
    output logic off
);
    seq_state_e state;
    logic       load;
    logic       sel_settle;
    logic       tmr_done;

    pwr_seq_timer #(
        .STEP_CYCLES  (STEP_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .sel_settle(sel_settle),
        .done      (tmr_done)
    );

    pwr_seq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .down_req  (down_req),
        .tmr_done  (tmr_done),
        .state     (state),
        .load      (load),
        .sel_settle(sel_settle)
    );

    pwr_seq_drive drive_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .bat_en   (bat_en),
        .io_en    (io_en),
        .chip_en  (chip_en),
        .mod_rst_n(mod_rst_n),
        .ready    (ready),
        .off      (off)
    );

endmodule

// File: rtl/pwr_seq_chk.sv
// Property checker for the power sequencer, bound to the top module.
// Watches only the output pins; the settle window is measured with a
// saturating counter rather than a long $past.
module pwr_seq_chk #(
    parameter int SETTLE_CYCLES = 1250000
) (
    input logic clk,
    input logic rst_n,
    input logic bat_en,
    input logic io_en,
    input logic chip_en,
    input logic mod_rst_n,
    input logic ready,
    input logic off
);
    localparam int WW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [WW-1:0] WMAX = {WW{1'b1}};

    logic [WW-1:0] wait_q;

    // Count cycles spent with chip enabled and reset still held.
    always_ff @(posedge clk) begin
        if (!rst_n || !chip_en)           wait_q <= '0;
        else if (!mod_rst_n && wait_q != WMAX) wait_q <= wait_q + 1'b1;
    end

    AST_IO_NEEDS_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> bat_en);                                          // R9
    AST_CHIP_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |-> io_en);                                         // R9
    AST_REL_NEEDS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_n |-> chip_en);                                     // R9
    AST_ONE_LINE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bat_en, io_en, chip_en, mod_rst_n} ^
                   $past({bat_en, io_en, chip_en, mod_rst_n})) <= 1); // R9
    AST_READY_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mod_rst_n);                                       // R4
    AST_READY_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(mod_rst_n));                         // R4
    AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rst_n) |-> (wait_q == WW'(SETTLE_CYCLES)));       // R3
    AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> !(bat_en || io_en || chip_en || mod_rst_n || ready)); // R5

endmodule

bind pwr_seq_top pwr_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bat_en   (bat_en),
    .io_en    (io_en),
    .chip_en  (chip_en),
    .mod_rst_n(mod_rst_n),
    .ready    (ready),
    .off      (off)
);

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
    localparam int STEP   = 3;
    localparam int SETTLE = 20;
    localparam int NVEC   = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0;
    logic down_req = 1'b0;
    logic bat_en, io_en, chip_en, mod_rst_n, ready, off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_seq_top #(.STEP_CYCLES(STEP), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
        .bat_en(bat_en), .io_en(io_en), .chip_en(chip_en),
        .mod_rst_n(mod_rst_n), .ready(ready), .off(off)
    );

    // Vector: {up, down, cycles to wait, expected {bat,io,chip,rel,ready,off}, req no.}
    // Timing with STEP=3, SETTLE=20, counted from the negedge the request is applied.
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'd1,  6'b000001, 4'd2}, // R2 outputs lag request
        {1'b0, 1'b0, 8'd1,  6'b100000, 4'd2}, // R2 battery first
        {1'b0, 1'b0, 8'd2,  6'b100000, 4'd2}, // R2 battery alone for STEP
        {1'b0, 1'b0, 8'd1,  6'b110000, 4'd2}, // R2 I/O rail
        {1'b0, 1'b0, 8'd2,  6'b110000, 4'd2}, // R2
        {1'b0, 1'b0, 8'd1,  6'b111000, 4'd2}, // R2 chip enable
        {1'b0, 1'b0, 8'd19, 6'b111000, 4'd3}, // R3 still settling
        {1'b0, 1'b0, 8'd1,  6'b111100, 4'd3}, // R3 reset released
        {1'b0, 1'b0, 8'd1,  6'b111110, 4'd4}, // R4 ready one cycle later
        {1'b1, 1'b0, 8'd5,  6'b111110, 4'd8}, // R8 up while running
        {1'b0, 1'b1, 8'd1,  6'b111110, 4'd5}, // R5 lag
        {1'b0, 1'b0, 8'd1,  6'b111000, 4'd5}, // R5 reset and ready drop
        {1'b0, 1'b0, 8'd2,  6'b111000, 4'd5}, // R5
        {1'b0, 1'b0, 8'd1,  6'b110000, 4'd5}, // R5 chip enable drops
        {1'b0, 1'b0, 8'd3,  6'b100000, 4'd5}, // R5 I/O drops
        {1'b0, 1'b0, 8'd3,  6'b000001, 4'd5}, // R5 battery drops, off
        {1'b1, 1'b0, 8'd2,  6'b100000, 4'd6}, // R6 start up
        {1'b0, 1'b1, 8'd4,  6'b100000, 4'd6}, // R6 abort in battery step
        {1'b0, 1'b0, 8'd1,  6'b000001, 4'd6}, // R6 unwound to off
        {1'b1, 1'b0, 8'd10, 6'b111000, 4'd6}, // R6 up into settle wait
        {1'b0, 1'b1, 8'd4,  6'b111000, 4'd6}, // R6 abort during settle
        {1'b1, 1'b0, 8'd1,  6'b110000, 4'd8}, // R8 up during power-down
        {1'b0, 1'b0, 8'd3,  6'b100000, 4'd6}, // R6
        {1'b0, 1'b0, 8'd3,  6'b000001, 4'd6}, // R6 off reached
        {1'b1, 1'b1, 8'd3,  6'b000001, 4'd7}, // R7 both at once
        {1'b0, 1'b1, 8'd3,  6'b000001, 4'd7}  // R7 down while off
    };

    function automatic logic [5:0] outs();
        return {bat_en, io_en, chip_en, mod_rst_n, ready, off};
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Apply one request pulse, wait, then compare the outputs.
    task automatic step(input logic u, input logic d, input int dly,
                        input string req, input logic [5:0] exp);
        up_req   = u;
        down_req = d;
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (k == 0) begin
                up_req   = 1'b0;
                down_req = 1'b0;
            end
        end
        check(req, outs(), exp);
    endtask

    // R9 line nesting sampled every cycle out of reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if ((io_en && !bat_en) || (chip_en && !io_en) || (mod_rst_n && !chip_en)) begin
                errors++;
                $display("FAIL R9: got %b expected nested lines", outs());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", outs(), 6'b000001);          // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 6'b000001);          // R1 idle after release
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][19], VEC[i][18], int'(VEC[i][17:10]),
                 $sformatf("R%0d", VEC[i][3:0]), VEC[i][9:4]);
        end
        // R1 reset while running drops every line at once.
        step(1'b1, 1'b0, 40, "R2", 6'b111110);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", outs(), 6'b000001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b1, 1'b0, 40, "R2", 6'b111110);   // R2 second power-up
        step(1'b0, 1'b1, 11, "R5", 6'b000001);   // R5 full power-down
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule